// File: doc/BRIEF.md
# Set-Associative Translation Lookaside Buffer

This block caches recent virtual-to-physical page translations in front of a page table walker. A lookup presents a virtual page number. The low bits of that number pick one set, and the remaining high bits form a tag. The tag is compared against every way of that set in parallel. On a hit, the physical page number and the three permission bits come back combinationally in the same cycle, so no page table memory access is needed.

On a miss, the block raises a miss flag and leaves the table walk to the walker. When the walker has the entry, it writes it back through the fill port. The new entry can be looked up from the next cycle. A single-cycle flush input drops every cached translation, for example on an address space switch.

A fill is placed in a fixed order of preference:
1. A valid way of the set that already holds the same tag is overwritten.
2. Otherwise, the lowest-numbered invalid way is used.
3. Otherwise, a per-set round-robin pointer picks the victim and then moves on.

Top module: `tlb_xlate`

## Requirements
- R1: After reset every entry is invalid, so every lookup reports a miss until a fill is made.
- R2: The set index is the two least significant VPN bits and the tag is the six upper VPN bits (default 8-bit VPN). An entry hits only for its exact VPN: the same set with another tag misses, and the same tag in another set misses. For example, VPN 0x0F (set 3, tag 0x03) filled with PPN 0x0D hits with PPN 0x0D.
- R3: A hit is reported combinationally in the cycle of the lookup. It returns the stored PPN on `ppn_o` and the stored permissions on `perm_o`, with bit 0 = read, bit 1 = write and bit 2 = supervisor.
- R4: `miss_o` is high exactly when a lookup is requested and no valid way matches. `hit_o` and `miss_o` are never both high, both are low when no lookup is requested, and `ppn_o` and `perm_o` are zero unless `hit_o` is high.
- R5: A fill takes effect at the clock edge that ends its cycle. A lookup of the same VPN in the fill cycle sees the old contents, and a lookup one cycle later hits with the filled data.
- R6: A fill whose tag is not present goes to the lowest-numbered invalid way of its set, so four fills with distinct tags into one set are all retained.
- R7: A fill into a full set replaces the way named by that set's round-robin pointer. The pointer starts at way 0 after reset or flush and advances by one, wrapping, after each such replacement. The fifth distinct fill into a set therefore evicts the first entry filled, and the sixth evicts the second.
- R8: A fill whose tag matches a valid way of its set overwrites that way in place. It evicts nothing and does not advance the round-robin pointer.
- R9: A flush clears every valid bit and every round-robin pointer in one cycle. A lookup in the flush cycle reports a miss, and a fill in the flush cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lkp_vld_i | input | 1 | Lookup request |
| lkp_vpn_i | input | VPN_W | Virtual page number to translate |
| hit_o | output | 1 | Lookup matched a valid entry |
| miss_o | output | 1 | Lookup found no valid entry |
| ppn_o | output | PPN_W | Physical page number on hit, else zero |
| perm_o | output | 3 | Permissions on hit (bit 0 read, 1 write, 2 supervisor), else zero |
| fill_vld_i | input | 1 | Write a translation from the walker |
| fill_vpn_i | input | VPN_W | VPN of the filled translation |
| fill_ppn_i | input | PPN_W | PPN of the filled translation |
| fill_perm_i | input | 3 | Permissions of the filled translation |
| flush_i | input | 1 | Invalidate all entries |

## Verification
The properties assume clean handshakes: every request input is a known 0 or 1 from the first clock after reset, and the VPN and fill data are stable whenever their valid is high. The fill-visibility property also assumes that the walker does not flush in the cycle it checks.

The stimulus meets these assumptions by driving all inputs at the falling edge and returning every valid to zero between operations. It sets up eviction patterns one fill at a time, and raises flush together with a lookup and a fill only in the one step meant to test that overlap.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  // bit 0 read, bit 1 write, bit 2 supervisor
  typedef struct packed {
    logic sup;
    logic wr;
    logic rd;
  } perm_t;

  localparam int unsigned PERM_W = $bits(perm_t);
endpackage

// File: rtl/tlb_set_match.sv
module tlb_set_match #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned TAG_W = 6,
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0]  valid_i,
  input  logic [TAG_W-1:0] tag_i [WAYS],
  input  logic [TAG_W-1:0] key_i,
  output logic             hit_o,
  output logic [WAYS-1:0]  oh_o,
  output logic [WAY_W-1:0] idx_o
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign oh_o[w] = valid_i[w] && (tag_i[w] == key_i);
  end

  assign hit_o = |oh_o;

  always_comb begin
    idx_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (oh_o[w]) idx_o = WAY_W'(w);
    end
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int unsigned WAYS = 4,
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0]  valid_i,
  input  logic             match_i,
  input  logic [WAY_W-1:0] match_idx_i,
  input  logic [WAY_W-1:0] rr_i,
  output logic [WAY_W-1:0] way_o,
  output logic             evict_o
);
  always_comb begin
    way_o   = rr_i;
    evict_o = 1'b1;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid_i[w]) begin
        way_o   = WAY_W'(w);
        evict_o = 1'b0;
      end
    end
    if (match_i) begin
      way_o   = match_idx_i;
      evict_o = 1'b0;
    end
  end
endmodule

// File: rtl/tlb_store.sv
module tlb_store
  import tlb_pkg::*;
#(
  parameter int unsigned SETS  = 4,
  parameter int unsigned WAYS  = 4,
  parameter int unsigned TAG_W = 6,
  parameter int unsigned PPN_W = 6,
  localparam int unsigned IDX_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             we_i,
  input  logic             adv_i,
  input  logic [IDX_W-1:0] wr_set_i,
  input  logic [WAY_W-1:0] wr_way_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  logic [PPN_W-1:0] wr_ppn_i,
  input  perm_t            wr_perm_i,
  input  logic [IDX_W-1:0] a_set_i,
  output logic [WAYS-1:0]  a_valid_o,
  output logic [TAG_W-1:0] a_tag_o  [WAYS],
  output logic [PPN_W-1:0] a_ppn_o  [WAYS],
  output perm_t            a_perm_o [WAYS],
  input  logic [IDX_W-1:0] b_set_i,
  output logic [WAYS-1:0]  b_valid_o,
  output logic [TAG_W-1:0] b_tag_o  [WAYS],
  output logic [WAY_W-1:0] b_rr_o
);
  logic [WAYS-1:0]  valid_q [SETS];
  logic [WAY_W-1:0] rr_q    [SETS];
  logic [TAG_W-1:0] tag_q   [SETS][WAYS];
  logic [PPN_W-1:0] ppn_q   [SETS][WAYS];
  perm_t            perm_q  [SETS][WAYS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        rr_q[s]    <= '0;
      end
    end else if (flush_i) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        rr_q[s]    <= '0;
      end
    end else if (we_i) begin
      valid_q[wr_set_i][wr_way_i] <= 1'b1;
      if (adv_i) begin
        rr_q[wr_set_i] <= (rr_q[wr_set_i] == WAY_W'(WAYS - 1)) ? '0 : rr_q[wr_set_i] + 1'b1;
      end
    end
  end

  // payload needs no reset: qualified by valid
  always_ff @(posedge clk_i) begin
    if (we_i && !flush_i) begin
      tag_q[wr_set_i][wr_way_i]  <= wr_tag_i;
      ppn_q[wr_set_i][wr_way_i]  <= wr_ppn_i;
      perm_q[wr_set_i][wr_way_i] <= wr_perm_i;
    end
  end

  assign a_valid_o = valid_q[a_set_i];
  assign b_valid_o = valid_q[b_set_i];
  assign b_rr_o    = rr_q[b_set_i];

  for (genvar w = 0; w < WAYS; w++) begin : g_rd
    assign a_tag_o[w]  = tag_q[a_set_i][w];
    assign a_ppn_o[w]  = ppn_q[a_set_i][w];
    assign a_perm_o[w] = perm_q[a_set_i][w];
    assign b_tag_o[w]  = tag_q[b_set_i][w];
  end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int unsigned VPN_W = 8,
  parameter int unsigned PPN_W = 6,
  parameter int unsigned SETS  = 4,
  parameter int unsigned WAYS  = 4,
  localparam int unsigned IDX_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int unsigned TAG_W = VPN_W - IDX_W,
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lkp_vld_i,
  input  logic [VPN_W-1:0] lkp_vpn_i,
  output logic             hit_o,
  output logic             miss_o,
  output logic [PPN_W-1:0] ppn_o,
  output logic [2:0]       perm_o,
  input  logic             fill_vld_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PPN_W-1:0] fill_ppn_i,
  input  logic [2:0]       fill_perm_i,
  input  logic             flush_i
);
  logic [IDX_W-1:0] lkp_set, fill_set;
  logic [TAG_W-1:0] lkp_tag, fill_tag;

  assign lkp_set  = lkp_vpn_i[IDX_W-1:0];
  assign lkp_tag  = lkp_vpn_i[VPN_W-1:IDX_W];
  assign fill_set = fill_vpn_i[IDX_W-1:0];
  assign fill_tag = fill_vpn_i[VPN_W-1:IDX_W];

  logic [WAYS-1:0]  a_valid, b_valid;
  logic [TAG_W-1:0] a_tag [WAYS];
  logic [TAG_W-1:0] b_tag [WAYS];
  logic [PPN_W-1:0] a_ppn [WAYS];
  perm_t            a_perm [WAYS];
  logic [WAY_W-1:0] b_rr;

  logic             we, evict;
  logic [WAY_W-1:0] wr_way;

  assign we = fill_vld_i && !flush_i;

  tlb_store #(
    .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .PPN_W(PPN_W)
  ) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (flush_i),
    .we_i      (we),
    .adv_i     (evict),
    .wr_set_i  (fill_set),
    .wr_way_i  (wr_way),
    .wr_tag_i  (fill_tag),
    .wr_ppn_i  (fill_ppn_i),
    .wr_perm_i (perm_t'(fill_perm_i)),
    .a_set_i   (lkp_set),
    .a_valid_o (a_valid),
    .a_tag_o   (a_tag),
    .a_ppn_o   (a_ppn),
    .a_perm_o  (a_perm),
    .b_set_i   (fill_set),
    .b_valid_o (b_valid),
    .b_tag_o   (b_tag),
    .b_rr_o    (b_rr)
  );

  logic             lkp_match;
  logic [WAYS-1:0]  lkp_oh;
  logic [WAY_W-1:0] lkp_idx;

  tlb_set_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lkp_cmp (
    .valid_i (a_valid),
    .tag_i   (a_tag),
    .key_i   (lkp_tag),
    .hit_o   (lkp_match),
    .oh_o    (lkp_oh),
    .idx_o   (lkp_idx)
  );

  logic             fill_match;
  logic [WAYS-1:0]  fill_oh;
  logic [WAY_W-1:0] fill_idx;

  tlb_set_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_fill_cmp (
    .valid_i (b_valid),
    .tag_i   (b_tag),
    .key_i   (fill_tag),
    .hit_o   (fill_match),
    .oh_o    (fill_oh),
    .idx_o   (fill_idx)
  );

  tlb_victim #(.WAYS(WAYS)) u_victim (
    .valid_i     (b_valid),
    .match_i     (fill_match),
    .match_idx_i (fill_idx),
    .rr_i        (b_rr),
    .way_o       (wr_way),
    .evict_o     (evict)
  );

  logic             hit;
  logic [PPN_W-1:0] ppn_sel;
  perm_t            perm_sel;

  assign hit = lkp_vld_i && !flush_i && lkp_match;

  // one-hot AND-OR mux, zero when nothing matches
  always_comb begin
    ppn_sel  = '0;
    perm_sel = '0;
    for (int w = 0; w < WAYS; w++) begin
      ppn_sel  = ppn_sel  | (a_ppn[w]  & {PPN_W{lkp_oh[w]}});
      perm_sel = perm_sel | (a_perm[w] & {PERM_W{lkp_oh[w]}});
    end
  end

  assign hit_o  = hit;
  assign miss_o = lkp_vld_i && !hit;
  assign ppn_o  = hit ? ppn_sel : '0;
  assign perm_o = hit ? perm_sel : '0;

  logic unused_idx;
  assign unused_idx = ^{lkp_idx, fill_oh};
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
  parameter int unsigned VPN_W = 8,
  parameter int unsigned PPN_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             lkp_vld_i,
  input logic [VPN_W-1:0] lkp_vpn_i,
  input logic             hit_o,
  input logic             miss_o,
  input logic [PPN_W-1:0] ppn_o,
  input logic [2:0]       perm_o,
  input logic             fill_vld_i,
  input logic [VPN_W-1:0] fill_vpn_i,
  input logic [PPN_W-1:0] fill_ppn_i,
  input logic             flush_i
);
  p_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_o && miss_o));

  p_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lkp_vld_i |-> (!hit_o && !miss_o));

  p_zero_on_miss_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (ppn_o == '0 && perm_o == '0));

  p_flush_miss_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i && lkp_vld_i) |-> miss_o);

  p_flush_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i ##1 lkp_vld_i |-> miss_o);

  p_fill_visible_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_vld_i && !flush_i) ##1 (lkp_vld_i && !flush_i && lkp_vpn_i == $past(fill_vpn_i))
    |-> (hit_o && ppn_o == $past(fill_ppn_i)));
endmodule

bind tlb_xlate tlb_xlate_chk #(.VPN_W(VPN_W), .PPN_W(PPN_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .lkp_vld_i  (lkp_vld_i),
  .lkp_vpn_i  (lkp_vpn_i),
  .hit_o      (hit_o),
  .miss_o     (miss_o),
  .ppn_o      (ppn_o),
  .perm_o     (perm_o),
  .fill_vld_i (fill_vld_i),
  .fill_vpn_i (fill_vpn_i),
  .fill_ppn_i (fill_ppn_i),
  .flush_i    (flush_i)
);

// File: tb/tlb_xlate_test.sv
module tlb_xlate_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       lkp_vld_i = 1'b0;
  logic [7:0] lkp_vpn_i = '0;
  logic       hit_o, miss_o;
  logic [5:0] ppn_o;
  logic [2:0] perm_o;
  logic       fill_vld_i = 1'b0;
  logic [7:0] fill_vpn_i = '0;
  logic [5:0] fill_ppn_i = '0;
  logic [2:0] fill_perm_i = '0;
  logic       flush_i = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tlb_xlate uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .lkp_vld_i(lkp_vld_i), .lkp_vpn_i(lkp_vpn_i),
    .hit_o(hit_o), .miss_o(miss_o), .ppn_o(ppn_o), .perm_o(perm_o),
    .fill_vld_i(fill_vld_i), .fill_vpn_i(fill_vpn_i),
    .fill_ppn_i(fill_ppn_i), .fill_perm_i(fill_perm_i),
    .flush_i(flush_i)
  );

  typedef struct packed {
    logic       fill;
    logic [7:0] vpn;
    logic [5:0] ppn;
    logic [2:0] perm;
    logic       hit;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 8'h0F, 6'h00, 3'b000, 1'b0},  // R1 empty
    '{1'b1, 8'h0F, 6'h0D, 3'b011, 1'b0},  // R2 example fill
    '{1'b0, 8'h0F, 6'h0D, 3'b011, 1'b1},  // R2 R3 hit
    '{1'b0, 8'h2E, 6'h00, 3'b000, 1'b0},  // R4 miss set 2
    '{1'b0, 8'h1F, 6'h00, 3'b000, 1'b0},  // R2 set 3 other tag
    '{1'b0, 8'h0C, 6'h00, 3'b000, 1'b0},  // R2 tag 3 other set
    '{1'b1, 8'h2E, 6'h11, 3'b100, 1'b0},
    '{1'b0, 8'h2E, 6'h11, 3'b100, 1'b1},  // R3 sup only
    '{1'b0, 8'h0F, 6'h0D, 3'b011, 1'b1},  // R2 still present
    '{1'b0, 8'h3E, 6'h00, 3'b000, 1'b0}   // R2 set 2 other tag
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // lookup at falling edge, sample before the rising edge
  task automatic look(string req, logic [7:0] vpn, logic h, logic [5:0] p, logic [2:0] pm);
    @(negedge clk);
    lkp_vld_i = 1'b1;
    lkp_vpn_i = vpn;
    #1;
    check(req, {29'd0, hit_o, miss_o, 1'b0}, {29'd0, h, ~h, 1'b0});
    check(req, {23'd0, ppn_o, perm_o}, h ? {23'd0, p, pm} : 32'd0);
    @(negedge clk);
    lkp_vld_i = 1'b0;
  endtask

  task automatic fill(logic [7:0] vpn, logic [5:0] p, logic [2:0] pm);
    @(negedge clk);
    fill_vld_i  = 1'b1;
    fill_vpn_i  = vpn;
    fill_ppn_i  = p;
    fill_perm_i = pm;
    @(negedge clk);
    fill_vld_i = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state, idle outputs low (R4)
    check("R1", {30'd0, hit_o, miss_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R4", {30'd0, hit_o, miss_o}, 32'd0);
    look("R1", 8'h00, 1'b0, 6'h0, 3'b0);
    look("R1", 8'hFF, 1'b0, 6'h0, 3'b0);

    for (int i = 0; i < NV; i++) begin
      if (TBL[i].fill) fill(TBL[i].vpn, TBL[i].ppn, TBL[i].perm);
      else look($sformatf("R2/R3/R4 vec %0d", i), TBL[i].vpn, TBL[i].hit, TBL[i].ppn, TBL[i].perm);
    end

    // R6 four distinct tags into set 1
    fill(8'h05, 6'h01, 3'b001);
    fill(8'h09, 6'h02, 3'b010);
    fill(8'h0D, 6'h03, 3'b011);
    fill(8'h11, 6'h04, 3'b111);
    look("R6", 8'h05, 1'b1, 6'h01, 3'b001);
    look("R6", 8'h09, 1'b1, 6'h02, 3'b010);
    look("R6", 8'h0D, 1'b1, 6'h03, 3'b011);
    look("R6", 8'h11, 1'b1, 6'h04, 3'b111);

    // R7 round-robin from way 0
    fill(8'h15, 6'h05, 3'b001);
    look("R7", 8'h05, 1'b0, 6'h0, 3'b0);
    look("R7", 8'h15, 1'b1, 6'h05, 3'b001);
    look("R7", 8'h09, 1'b1, 6'h02, 3'b010);
    fill(8'h19, 6'h06, 3'b001);
    look("R7", 8'h09, 1'b0, 6'h0, 3'b0);
    look("R7", 8'h19, 1'b1, 6'h06, 3'b001);
    look("R7", 8'h0D, 1'b1, 6'h03, 3'b011);

    // R8 overwrite in place, pointer not moved
    fill(8'h0D, 6'h2A, 3'b110);
    look("R8", 8'h0D, 1'b1, 6'h2A, 3'b110);
    look("R8", 8'h11, 1'b1, 6'h04, 3'b111);
    look("R8", 8'h15, 1'b1, 6'h05, 3'b001);
    look("R8", 8'h19, 1'b1, 6'h06, 3'b001);
    fill(8'h1D, 6'h07, 3'b001);  // pointer at way 2 -> evicts 0x0D
    look("R8", 8'h0D, 1'b0, 6'h0, 3'b0);
    look("R8", 8'h11, 1'b1, 6'h04, 3'b111);
    look("R8", 8'h1D, 1'b1, 6'h07, 3'b001);

    // R5 same-cycle lookup sees old contents
    @(negedge clk);
    fill_vld_i = 1'b1; fill_vpn_i = 8'h31; fill_ppn_i = 6'h15; fill_perm_i = 3'b011;
    lkp_vld_i = 1'b1; lkp_vpn_i = 8'h31;
    #1;
    check("R5 fill cycle", {31'd0, miss_o}, 32'd1);
    @(negedge clk);
    fill_vld_i = 1'b0;
    #1;
    check("R5 next cycle", {25'd0, hit_o, ppn_o}, {25'd0, 1'b1, 6'h15});
    @(negedge clk);
    lkp_vld_i = 1'b0;

    // R9 flush with lookup and fill in same cycle
    @(negedge clk);
    flush_i = 1'b1;
    fill_vld_i = 1'b1; fill_vpn_i = 8'h21; fill_ppn_i = 6'h09; fill_perm_i = 3'b001;
    lkp_vld_i = 1'b1; lkp_vpn_i = 8'h11;
    #1;
    check("R9 flush cycle", {30'd0, hit_o, miss_o}, 32'd1);
    @(negedge clk);
    flush_i = 1'b0; fill_vld_i = 1'b0; lkp_vld_i = 1'b0;
    look("R9", 8'h11, 1'b0, 6'h0, 3'b0);
    look("R9", 8'h0F, 1'b0, 6'h0, 3'b0);
    look("R9 dropped fill", 8'h21, 1'b0, 6'h0, 3'b0);
    look("R9", 8'h31, 1'b0, 6'h0, 3'b0);

    // R9 pointers back at way 0: fifth fill evicts first
    fill(8'h41, 6'h01, 3'b001);
    fill(8'h45, 6'h02, 3'b001);
    fill(8'h49, 6'h03, 3'b001);
    fill(8'h4D, 6'h04, 3'b001);
    fill(8'h51, 6'h05, 3'b001);
    look("R9 rr reset", 8'h41, 1'b0, 6'h0, 3'b0);
    look("R9 rr reset", 8'h45, 1'b1, 6'h02, 3'b001);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule